// File: doc/BRIEF.md
# Page Register Serial Read Column Pointer

This block generates the column index for serial reads out of a 528-column page register. The register has 512 main columns, split into a lower and an upper half of 256 columns each, followed by 16 spare columns at indices 512 to 527. A half-select command picks the half that the next address load starts in. When the address sequence completes, the pointer loads the latched column byte, offset into the chosen half. Once a load has used the upper half, the half selection drops back to the lower half on its own. After that, every high-to-low transition of the active-low read strobe moves the pointer forward by one column.

A static spare-exclude input sets the end of the sequence. When it is low, reading runs through the spare columns and stops at 527. When it is high, reading stops at the last main column, 511. At the stop column the pointer holds its value and raises a page-end flag. While the busy input is high, read strobe edges are discarded. All inputs are sampled on the rising edge of the block clock, and the read strobe edge is detected against its value sampled in the previous cycle.

Top module: `pgptr_col_ptr`

## Requirements
- R1: After reset the column index is 0, the page-end flag is 0 and the half selection is the lower half.
- R2: An address-complete strobe with the lower half selected (half-select value 0) loads the column byte unchanged into the column index on the next clock edge.
- R3: An address-complete strobe with the upper half selected (half-select value 1) loads 256 plus the column byte. The most recent half-select command before the load decides which half is used.
- R4: After a load that used the upper half, the half selection returns to the lower half, so a later load with no new half-select command starts in the lower half.
- R5: Each high-to-low transition of the read strobe, seen between two consecutive clock samples, increments the column index by exactly one. A strobe that is held low or that rises does not move the index.
- R6: Read strobe falling edges that are sampled while busy is high leave the column index unchanged.
- R7: With spare-exclude low, the index counts into the spare columns, stops at 527 and holds there, and the page-end flag is 1 exactly while the index is 527.
- R8: With spare-exclude high, the index stops at 511 and holds there, and the page-end flag is 1 while the index is at 511.
- R9: When an address-complete strobe and a read strobe falling edge fall in the same cycle, the load wins and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_done | input | 1 | Address sequence complete, loads the start column |
| col_byte | input | BYTE_W (8) | Latched column address byte |
| half_cmd_vld | input | 1 | Half-select command strobe |
| half_cmd_hi | input | 1 | Half chosen by the command: 0 lower, 1 upper |
| rd_n | input | 1 | Serial read strobe, active low |
| busy | input | 1 | Array operation in progress; read strobes ignored |
| spare_off | input | 1 | 1 excludes the spare columns from the sequence |
| col_idx | output | PTR_W (10) | Column index of the byte to fetch |
| page_end | output | 1 | Index has reached the last column of the sequence |

## Verification
There are two kinds of state fault to watch for. A fault in the half-select register appears only at the next address load, where the loaded index is off by exactly 256, so the bench reads the index right after each load. A fault in the strobe edge detector or the busy gating appears as an index that is one count too high or too low after a single strobe, and it is visible one clock after that strobe. Limit faults appear only at columns 511 and 527, so runs are driven up to and past both stop columns.

// File: rtl/pgptr_pkg.sv
package pgptr_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // First column of a serial read: the byte, shifted into the upper half when selected
  function automatic int unsigned start_col(input logic hi, input int unsigned byte_v,
                                            input int unsigned half_cols);
    return hi ? (half_cols + byte_v) : byte_v;
  endfunction

  // Stop column of the sequence for a given spare-exclude setting
  function automatic int unsigned stop_col(input logic excl_spare, input int unsigned main_cols,
                                           input int unsigned spare_cols);
    return excl_spare ? (main_cols - 1) : (main_cols + spare_cols - 1);
  endfunction

endpackage

// File: rtl/pgptr_fall_det.sv
module pgptr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);

  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe_n;
  end

  assign fall = strobe_q & ~strobe_n;

endmodule

// File: rtl/pgptr_half_sel.sv
module pgptr_half_sel
  import pgptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_vld,
  input  logic  sel_hi,
  input  logic  load,
  output half_e mode
);

  half_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= HALF_LO;
    else if (sel_vld) mode_q <= sel_hi ? HALF_HI : HALF_LO;
    else if (load)    mode_q <= HALF_LO;
  end

  assign mode = mode_q;

endmodule

// File: rtl/pgptr_counter.sv
module pgptr_counter
  import pgptr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAIN_COLS  = 512,
  parameter int SPARE_COLS = 16,
  localparam int HALF_COLS = MAIN_COLS / 2,
  localparam int PTR_W     = $clog2(MAIN_COLS + SPARE_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] col_byte,
  input  logic              half_hi,
  input  logic              step,
  input  logic              excl_spare,
  output logic [PTR_W-1:0]  ptr,
  output logic              at_end
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] start_v;
  logic [PTR_W-1:0] stop_v;

  always_comb begin
    start_v = PTR_W'(start_col(half_hi, int'(unsigned'(col_byte)), HALF_COLS));
    stop_v  = PTR_W'(stop_col(excl_spare, MAIN_COLS, SPARE_COLS));
  end

  assign at_end = (ptr_q >= stop_v);

  always_comb begin
    ptr_d = ptr_q;
    if (load)                 ptr_d = start_v;
    else if (step && !at_end) ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/pgptr_col_ptr.sv
module pgptr_col_ptr
  import pgptr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAIN_COLS  = 512,
  parameter int SPARE_COLS = 16,
  localparam int PTR_W     = $clog2(MAIN_COLS + SPARE_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_done,
  input  logic [BYTE_W-1:0] col_byte,
  input  logic              half_cmd_vld,
  input  logic              half_cmd_hi,
  input  logic              rd_n,
  input  logic              busy,
  input  logic              spare_off,
  output logic [PTR_W-1:0]  col_idx,
  output logic              page_end
);

  // Named internal events, observed by the bound checker
  logic  rd_fall;
  logic  rd_step;
  half_e half_mode;
  logic  half_hi;

  pgptr_fall_det i_fall (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (rd_n),
    .fall     (rd_fall)
  );

  assign rd_step = rd_fall & ~busy;

  pgptr_half_sel i_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_vld (half_cmd_vld),
    .sel_hi  (half_cmd_hi),
    .load    (addr_done),
    .mode    (half_mode)
  );

  assign half_hi = (half_mode == HALF_HI);

  pgptr_counter #(
    .BYTE_W     (BYTE_W),
    .MAIN_COLS  (MAIN_COLS),
    .SPARE_COLS (SPARE_COLS)
  ) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (addr_done),
    .col_byte   (col_byte),
    .half_hi    (half_hi),
    .step       (rd_step),
    .excl_spare (spare_off),
    .ptr        (col_idx),
    .at_end     (page_end)
  );

endmodule

// File: rtl/pgptr_col_ptr_chk.sv
module pgptr_col_ptr_chk #(
  parameter int BYTE_W     = 8,
  parameter int MAIN_COLS  = 512,
  parameter int SPARE_COLS = 16,
  localparam int HALF_COLS = MAIN_COLS / 2,
  localparam int PTR_W     = $clog2(MAIN_COLS + SPARE_COLS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_done,
  input logic [BYTE_W-1:0] col_byte,
  input logic              half_cmd_vld,
  input logic              busy,
  input logic              spare_off,
  input logic              rd_fall,
  input logic              half_hi,
  input logic [PTR_W-1:0]  col_idx,
  input logic              page_end
);

  AST_LOAD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !half_hi) |=> (col_idx == PTR_W'($past(col_byte)))); // R2

  AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && half_hi) |=> (col_idx == PTR_W'(HALF_COLS) + PTR_W'($past(col_byte)))); // R3

  AST_HALF_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !half_cmd_vld) |=> !half_hi); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !busy && !addr_done && !page_end) |=> (col_idx == $past(col_idx) + PTR_W'(1))); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !addr_done) |=> $stable(col_idx)); // R6

  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (page_end && !addr_done) |=> $stable(col_idx)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (col_idx <= PTR_W'(MAIN_COLS + SPARE_COLS - 1))); // R7

  AST_MAIN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_off && !addr_done && col_idx == PTR_W'(MAIN_COLS - 1)) |=> $stable(col_idx)); // R8

endmodule

bind pgptr_col_ptr pgptr_col_ptr_chk #(
  .BYTE_W     (BYTE_W),
  .MAIN_COLS  (MAIN_COLS),
  .SPARE_COLS (SPARE_COLS)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_done    (addr_done),
  .col_byte     (col_byte),
  .half_cmd_vld (half_cmd_vld),
  .busy         (busy),
  .spare_off    (spare_off),
  .rd_fall      (rd_fall),
  .half_hi      (half_hi),
  .col_idx      (col_idx),
  .page_end     (page_end)
);

// File: tb/test_pgptr_col_ptr.sv
module test_pgptr_col_ptr;

  localparam int PERIOD = 20;

  localparam logic [2:0] OP_SEL   = 3'd0;
  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_FALL  = 3'd2;
  localparam logic [2:0] OP_BFALL = 3'd3;
  localparam logic [2:0] OP_NFALL = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic       sp;
    logic [9:0] ptr;
    logic       eop;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{OP_LOAD,  8'h10, 1'b0, 10'd16,  1'b0, 4'd2},  // R2 lower-half load
    '{OP_FALL,  8'h00, 1'b0, 10'd17,  1'b0, 4'd5},  // R5 single edge
    '{OP_NFALL, 8'd3,  1'b0, 10'd20,  1'b0, 4'd5},  // R5 three edges
    '{OP_BFALL, 8'h00, 1'b0, 10'd20,  1'b0, 4'd6},  // R6 edge while busy
    '{OP_SEL,   8'h01, 1'b0, 10'd20,  1'b0, 4'd3},  // R3 select alone moves nothing
    '{OP_LOAD,  8'h05, 1'b0, 10'd261, 1'b0, 4'd3},  // R3 upper-half load
    '{OP_LOAD,  8'h05, 1'b0, 10'd5,   1'b0, 4'd4},  // R4 reverted to lower half
    '{OP_SEL,   8'h01, 1'b1, 10'd5,   1'b0, 4'd3},  // R3
    '{OP_LOAD,  8'hFE, 1'b1, 10'd510, 1'b0, 4'd3},  // R3
    '{OP_FALL,  8'h00, 1'b1, 10'd511, 1'b1, 4'd8},  // R8 reach main stop
    '{OP_FALL,  8'h00, 1'b1, 10'd511, 1'b1, 4'd8},  // R8 hold at main stop
    '{OP_FALL,  8'h00, 1'b0, 10'd512, 1'b0, 4'd7},  // R7 into spare
    '{OP_SEL,   8'h01, 1'b0, 10'd512, 1'b0, 4'd3},  // R3
    '{OP_LOAD,  8'hFA, 1'b0, 10'd506, 1'b0, 4'd3},  // R3
    '{OP_NFALL, 8'd21, 1'b0, 10'd527, 1'b1, 4'd7},  // R7 reach spare stop
    '{OP_FALL,  8'h00, 1'b0, 10'd527, 1'b1, 4'd7},  // R7 hold at 527
    '{OP_SEL,   8'h00, 1'b0, 10'd527, 1'b1, 4'd2},  // R2
    '{OP_LOAD,  8'h80, 1'b0, 10'd128, 1'b0, 4'd2},  // R2
    '{OP_SEL,   8'h01, 1'b0, 10'd128, 1'b0, 4'd4},  // R4
    '{OP_SEL,   8'h00, 1'b0, 10'd128, 1'b0, 4'd4},  // R4 last select wins
    '{OP_LOAD,  8'h03, 1'b0, 10'd3,   1'b0, 4'd4}   // R4
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_done = 1'b0;
  logic [7:0] col_byte = '0;
  logic       half_cmd_vld = 1'b0;
  logic       half_cmd_hi = 1'b0;
  logic       rd_n = 1'b1;
  logic       busy = 1'b0;
  logic       spare_off = 1'b0;
  logic [9:0] col_idx;
  logic       page_end;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pgptr_col_ptr i_pgptr_col_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_done    (addr_done),
    .col_byte     (col_byte),
    .half_cmd_vld (half_cmd_vld),
    .half_cmd_hi  (half_cmd_hi),
    .rd_n         (rd_n),
    .busy         (busy),
    .spare_off    (spare_off),
    .col_idx      (col_idx),
    .page_end     (page_end)
  );

  task automatic check(input string req, input logic [9:0] exp_ptr, input logic exp_eop);
    n_run++;
    if (col_idx !== exp_ptr || page_end !== exp_eop) begin
      n_fail++;
      $display("FAIL %s: col_idx=%0d page_end=%0b expected col_idx=%0d page_end=%0b",
               req, col_idx, page_end, exp_ptr, exp_eop);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic one_fall();
    rd_n = 1'b0; tick();
    rd_n = 1'b1; tick();
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] arg, input logic sp);
    spare_off = sp;
    case (op)
      OP_SEL:   begin half_cmd_vld = 1'b1; half_cmd_hi = arg[0]; tick(); half_cmd_vld = 1'b0; end
      OP_LOAD:  begin addr_done = 1'b1; col_byte = arg; tick(); addr_done = 1'b0; end
      OP_FALL:  one_fall();
      OP_BFALL: begin busy = 1'b1; one_fall(); busy = 1'b0; end
      OP_NFALL: for (int k = 0; k < int'(arg); k++) one_fall();
      default:  tick();
    endcase
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: col_idx=%0d expected run to complete", col_idx);
    finish_run();
  end

  initial begin
    tick(); tick();
    check("R1 reset state", 10'd0, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 reset held", 10'd0, 1'b0);

    // R5: strobe held low gives exactly one step
    rd_n = 1'b0; tick(); tick(); tick();
    check("R5 held low", 10'd1, 1'b0);
    rd_n = 1'b1; tick();
    check("R5 rising edge", 10'd1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].op, TBL[i].arg, TBL[i].sp);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].ptr, TBL[i].eop);
    end

    // R9: load and falling edge in the same cycle
    addr_done = 1'b1; col_byte = 8'h40; rd_n = 1'b0; tick();
    addr_done = 1'b0; rd_n = 1'b1; tick();
    check("R9 load beats edge", 10'd64, 1'b0);

    // R6: busy edge is not remembered once busy drops while strobe is low
    busy = 1'b1; rd_n = 1'b0; tick();
    busy = 1'b0; tick();
    rd_n = 1'b1; tick();
    check("R6 busy edge dropped", 10'd64, 1'b0);

    // R1: reset clears upper-half selection
    half_cmd_vld = 1'b1; half_cmd_hi = 1'b1; tick(); half_cmd_vld = 1'b0;
    rst_n = 1'b0; tick();
    check("R1 mid-run reset", 10'd0, 1'b0);
    rst_n = 1'b1; tick();
    apply(OP_LOAD, 8'h07, 1'b0);
    check("R1 half reset to lower", 10'd7, 1'b0);

    finish_run();
  end

endmodule